// File: doc/BRIEF.md
# Remapped Edge-Interrupt GPIO Controller

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, 102 by default. Each register type occupies a bank of consecutive 32-bit words, and a logical pin sits at one bit of one word in every bank. Software configures pins through a single-cycle register bus. Software can enable a pin, make it an output, set its output value and read its synchronised input level. It can also pick the edge that flags the pin, mask its interrupt and clear its latched status.

An optional remapping stage places logical pins at scrambled bit positions. With remapping on, pins 0 to 27 sit at positions 4 to 31, and pins 28 to 33 have no position. Pins 34 to 97 sit at positions 32 to 95, and pins 98 to 101 sit at positions 3 down to 0. The remaining positions below the pin count are dead. Positions at or above the pin count in the last word are not GPIO and behave as plain storage. Pin inputs pass through a two-flop synchroniser before event detection. All unmasked status bits are combined into one interrupt line.

The bus carries no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpx_remap_gpio`

## Requirements
- R1: After reset, no pin is driven and `irq` is low. The direction and mask banks read all ones. The enable, output, edge and status banks read zero.
- R2: The address is {type[2:0], word}, with type codes 0 enable, 1 output data, 2 direction, 3 input data, 4 mask, 5 status and 6 edge. The enable, output, direction, mask and edge banks read back the last word written to them.
- R3: A pin whose position has enable 1 and direction 0 asserts `pin_oe` and presents its output-data bit on `pin_out`. A direction bit of 1 makes the pin an input, with `pin_oe` low.
- R4: With the enable bank present, an enable bit of 0 keeps the pin's `pin_oe` low and stops its status bit from setting.
- R5: The input-data bank returns each pin's level two clock edges after it is applied. Writes to input-data bits that belong to pins are ignored.
- R6: In edge mode, an edge bit of 1 flags a rising edge and an edge bit of 0 flags a falling edge. The status bit sets on the third clock edge after the pin changes, whatever the mask bit is.
- R7: `irq` is high exactly when some pin status bit is 1 and its mask bit is 0. A mask bit of 1 disables that pin's interrupt.
- R8: A status write clears each pin bit written as 0 and leaves each bit written as 1 unchanged. A new event in the same cycle keeps its bit set.
- R9: Bits at or above the pin count in the last word store and return their written value in every bank, including input data and status. They never raise `irq`. Dead positions below the pin count never set status.
- R10: With remapping, pin 0 is at position 4, pin 27 at 31, pin 34 at 32, pin 97 at 95, pin 98 at 3 and pin 101 at 0. Pins 28 to 33 are never driven.
- R11: When the edge bank is removed by parameter, a pin flags while its synchronised level is high, and a cleared bit sets again while the level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3+log2(words) | Bank type (high bits) and word index (low bits) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels, indexed by logical pin |
| pin_out | output | NUM_PINS | Output value per logical pin |
| pin_oe | output | NUM_PINS | Output enable per logical pin |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong bit position in the remap shows at once on `pin_oe` after one direction write, because it drives the wrong logical pin or an unmapped pin. A broken synchroniser or edge selector shows when status is read three edges after a pin change: the status bit is missing or set for the wrong polarity. A status register that loses bits, or clears on a written 1, shows on the next status read or on `irq` in the cycle after the write. A storage bit in the last word that leaks into the interrupt shows as `irq` rising as soon as its mask is cleared.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RG_ENABLE = 3'd0,
    RG_OUT    = 3'd1,
    RG_DIR    = 3'd2,
    RG_IN     = 3'd3,
    RG_MASK   = 3'd4,
    RG_STAT   = 3'd5,
    RG_EDGE   = 3'd6,
    RG_NONE   = 3'd7
  } reg_sel_e;

  // Bit position of a logical pin, or -1 when the pin has no position.
  function automatic int pos_of_pin(input bit remap, input int npins, input int p);
    if (p >= npins) return -1;
    if (!remap) return p;
    if (p <= 27) return p + 4;
    if (p <= 33) return -1;
    if (p <= 97) return p - 2;
    if (p <= 101) return 101 - p;
    return -1;
  endfunction

  // Logical pin at a bit position, or -1 for a dead or non-GPIO position.
  function automatic int pin_of_pos(input bit remap, input int npins, input int b);
    int p;
    if (!remap) p = b;
    else if (b <= 3) p = 101 - b;
    else if (b <= 31) p = b - 4;
    else p = b + 2;
    if (p >= npins) return -1;
    if (pos_of_pin(remap, npins, p) != b) return -1;
    return p;
  endfunction
endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign sync_o = s2_q;
  assign prev_o = s3_q;

  // Synchronised level lags the pad by two edges.
  assert_sync_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpx_status.sv
module gpx_status #(
  parameter int            NB         = 32,
  parameter logic [NB-1:0] GPIO_BITS  = '1,
  parameter logic [NB-1:0] STORE_BITS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt_i,
  input  logic          wr_i,
  input  logic [NB-1:0] wsel_i,
  input  logic [NB-1:0] wval_i,
  input  logic [NB-1:0] mask_i,
  output logic [NB-1:0] stat_o,
  output logic          irq_o
);
  logic [NB-1:0] stat_q, stat_d, clr_vec, wr_sel;

  assign wr_sel  = wr_i ? wsel_i : '0;
  assign clr_vec = wr_sel & ~wval_i & GPIO_BITS;

  always_comb begin
    stat_d = (stat_q & ~clr_vec) | (evt_i & GPIO_BITS);
    stat_d = (stat_d & GPIO_BITS)
           | (((wr_sel & wval_i) | (~wr_sel & stat_q)) & STORE_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i & GPIO_BITS);

  assert_event_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_i) & GPIO_BITS & ~stat_q) == '0));

  assert_sticky_until_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q & ~clr_vec) & GPIO_BITS & ~stat_q) == '0));

  assert_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_vec & ~evt_i) & stat_q) == '0));
endmodule

// File: rtl/gpx_remap_gpio.sv
module gpx_remap_gpio #(
  parameter int NUM_PINS   = 102,
  parameter bit REMAP      = 1'b1,
  parameter bit HAS_ENABLE = 1'b1,
  parameter bit HAS_EDGE   = 1'b1,
  localparam int NW = (NUM_PINS + gpx_pkg::WORD_W - 1) / gpx_pkg::WORD_W,
  localparam int WB = (NW > 1) ? $clog2(NW) : 1,
  localparam int AW = 3 + WB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  import gpx_pkg::*;

  localparam int NB = NW * WORD_W;

  function automatic logic [NB-1:0] gpio_positions();
    logic [NB-1:0] v;
    v = '0;
    for (int b = 0; b < NB; b++) v[b] = (pin_of_pos(REMAP, NUM_PINS, b) >= 0);
    return v;
  endfunction

  function automatic logic [NB-1:0] store_positions();
    logic [NB-1:0] v;
    v = '0;
    for (int b = 0; b < NB; b++) v[b] = (b >= NUM_PINS);
    return v;
  endfunction

  function automatic logic [NB-1:0] merge(input logic [NB-1:0] old_v,
                                          input logic [NB-1:0] sel_v,
                                          input logic [NB-1:0] new_v);
    return (old_v & ~sel_v) | (new_v & sel_v);
  endfunction

  localparam logic [NB-1:0] GPIO_BITS  = gpio_positions();
  localparam logic [NB-1:0] STORE_BITS = store_positions();

  reg_sel_e       reg_sel;
  logic [WB-1:0]  word_idx;
  logic [NB-1:0]  wsel, wide_wd, rd_vec;
  logic [NB-1:0]  en_r, out_r, dir_r, mask_r, edge_r, inx_r;
  logic [NB-1:0]  en_ok, pos_sync, evt, stat_v, in_view;
  logic [NUM_PINS-1:0] sync_v, prev_v;

  assign reg_sel  = reg_sel_e'(bus_addr[AW-1:WB]);
  assign word_idx = bus_addr[WB-1:0];
  assign wide_wd  = {NW{bus_wdata}};

  for (genvar w = 0; w < NW; w++) begin : g_wsel
    assign wsel[w*WORD_W +: WORD_W] = (word_idx == WB'(w)) ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= '0;
      out_r  <= '0;
      dir_r  <= '1;
      mask_r <= '1;
      edge_r <= '0;
      inx_r  <= '0;
    end else if (bus_wr) begin
      case (reg_sel)
        RG_ENABLE: en_r   <= merge(en_r,   wsel, wide_wd);
        RG_OUT:    out_r  <= merge(out_r,  wsel, wide_wd);
        RG_DIR:    dir_r  <= merge(dir_r,  wsel, wide_wd);
        RG_MASK:   mask_r <= merge(mask_r, wsel, wide_wd);
        RG_EDGE:   edge_r <= merge(edge_r, wsel, wide_wd);
        RG_IN:     inx_r  <= merge(inx_r,  wsel & STORE_BITS, wide_wd);
        default:   ;
      endcase
    end
  end

  if (HAS_ENABLE) begin : g_en
    assign en_ok = en_r;
  end else begin : g_noen
    assign en_ok = '1;
  end

  gpx_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .sync_o (sync_v),
    .prev_o (prev_v)
  );

  // Per bit position: map back to the logical pin and form its event.
  for (genvar b = 0; b < NB; b++) begin : g_pos
    localparam int LP = pin_of_pos(REMAP, NUM_PINS, b);
    if (LP >= 0) begin : g_live
      logic trig;
      if (HAS_EDGE) begin : g_edge
        assign trig = edge_r[b] ? (sync_v[LP] & ~prev_v[LP])
                                : (~sync_v[LP] & prev_v[LP]);
      end else begin : g_level
        assign trig = sync_v[LP];
      end
      assign pos_sync[b] = sync_v[LP];
      assign evt[b]      = en_ok[b] & trig;
    end else begin : g_dead
      assign pos_sync[b] = 1'b0;
      assign evt[b]      = 1'b0;
    end
  end

  // Per logical pin: pick its bit position for drive.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BP = pos_of_pin(REMAP, NUM_PINS, p);
    if (BP >= 0) begin : g_map
      assign pin_out[p] = out_r[BP];
      assign pin_oe[p]  = en_ok[BP] & ~dir_r[BP];
    end else begin : g_nomap
      assign pin_out[p] = 1'b0;
      assign pin_oe[p]  = 1'b0;
    end
  end

  gpx_status #(.NB(NB), .GPIO_BITS(GPIO_BITS), .STORE_BITS(STORE_BITS)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .wr_i   (bus_wr && (reg_sel == RG_STAT)),
    .wsel_i (wsel),
    .wval_i (wide_wd),
    .mask_i (mask_r),
    .stat_o (stat_v),
    .irq_o  (irq)
  );

  assign in_view = (pos_sync & ~STORE_BITS) | (inx_r & STORE_BITS);

  always_comb begin
    case (reg_sel)
      RG_ENABLE: rd_vec = en_r;
      RG_OUT:    rd_vec = out_r;
      RG_DIR:    rd_vec = dir_r;
      RG_IN:     rd_vec = in_view;
      RG_MASK:   rd_vec = mask_r;
      RG_STAT:   rd_vec = stat_v;
      RG_EDGE:   rd_vec = edge_r;
      default:   rd_vec = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++)
      if (word_idx == WB'(w)) bus_rdata = rd_vec[w*WORD_W +: WORD_W];
  end

  if (HAS_ENABLE) begin : g_en_chk
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & ~$past(stat_v) & $past(~en_r) & GPIO_BITS) == '0));
  end
endmodule

// File: tb/gpx_remap_gpio_test.sv
module gpx_remap_gpio_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bwr = 1'b0;
  logic [4:0]   baddr = '0;
  logic [31:0]  bwdata = '0;
  logic [31:0]  brd;
  logic [101:0] pin_in = '0;
  logic [101:0] pin_out, pin_oe;
  logic         irq;

  logic         lwr = 1'b0;
  logic [3:0]   laddr = '0;
  logic [31:0]  lrd;
  logic [39:0]  lpin_in = '0;
  logic [39:0]  lpin_out, lpin_oe;
  logic         lirq;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_remap_gpio uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr), .bus_wdata(bwdata),
    .bus_rdata(brd), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  gpx_remap_gpio #(.NUM_PINS(40), .REMAP(1'b0), .HAS_ENABLE(1'b0), .HAS_EDGE(1'b0)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .bus_wr(lwr), .bus_addr(laddr), .bus_wdata(bwdata),
    .bus_rdata(lrd), .pin_in(lpin_in), .pin_out(lpin_out), .pin_oe(lpin_oe), .irq(lirq)
  );

  // {req[3:0], type[2:0], word[1:0], write data, expected read}
  localparam logic [72:0] VEC [7] = '{
    {4'd2, 3'd1, 2'd0, 32'hA5A50F0F, 32'hA5A50F0F},
    {4'd2, 3'd6, 2'd1, 32'h12345678, 32'h12345678},
    {4'd9, 3'd3, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFC0},
    {4'd9, 3'd5, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFC0},
    {4'd5, 3'd3, 2'd0, 32'hFFFFFFFF, 32'h00000000},
    {4'd2, 3'd4, 2'd2, 32'h00000000, 32'h00000000},
    {4'd2, 3'd4, 2'd3, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] t, input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    bwr = 1'b1; baddr = {t, w}; bwdata = d;
    @(negedge clk);
    bwr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] t, input logic [1:0] w, input logic [31:0] e,
                    input string tag);
    @(negedge clk);
    baddr = {t, w};
    #1 chk(128'(brd), 128'(e), tag);
  endtask

  task automatic lwrite(input logic [2:0] t, input logic w, input logic [31:0] d);
    @(negedge clk);
    lwr = 1'b1; laddr = {t, w}; bwdata = d;
    @(negedge clk);
    lwr = 1'b0;
  endtask

  task automatic lread(input logic [2:0] t, input logic w, input logic [31:0] e,
                       input string tag);
    @(negedge clk);
    laddr = {t, w};
    #1 chk(128'(lrd), 128'(e), tag);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog R1 actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] exp_oe;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(128'(pin_oe), '0, "R1 pin_oe");
    chk(128'(irq), '0, "R1 irq");
    rd(3'd2, 2'd0, 32'hFFFFFFFF, "R1 dir");
    rd(3'd4, 2'd1, 32'hFFFFFFFF, "R1 mask");
    rd(3'd5, 2'd0, 32'h0, "R1 status");
    rd(3'd0, 2'd2, 32'h0, "R1 enable");

    // Table: write then read back (R2 storage, R5 ignored input writes, R9 extra bits)
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:66], VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][68:66], VEC[i][65:64], VEC[i][31:0],
         $sformatf("R%0d table %0d", VEC[i][72:69], i));
    end
    #1 chk(128'(irq), '0, "R9 storage bits do not interrupt");

    // R3 / R10 drive through remapped positions
    wr(3'd0, 2'd0, 32'h18);
    wr(3'd1, 2'd0, 32'h10);
    wr(3'd2, 2'd0, 32'hFFFFFFE7);
    #1;
    exp_oe = '0; exp_oe[0] = 1'b1; exp_oe[98] = 1'b1;
    chk(128'(pin_oe), exp_oe, "R3 R10 drive pins 0 and 98");
    chk(128'(pin_out[0]), 128'(1), "R3 pin 0 value");
    chk(128'(pin_out[98]), 128'(0), "R3 pin 98 value");
    wr(3'd2, 2'd0, 32'hFFFFFFEF);
    #1;
    exp_oe = '0; exp_oe[0] = 1'b1;
    chk(128'(pin_oe), exp_oe, "R3 direction input stops drive");
    wr(3'd2, 2'd0, 32'hFFFFFFE7);
    wr(3'd0, 2'd0, 32'h08);
    #1;
    exp_oe = '0; exp_oe[98] = 1'b1;
    chk(128'(pin_oe), exp_oe, "R4 disabled pin not driven");

    // R10 full map
    for (int w = 0; w < 4; w++) begin
      wr(3'd0, 2'(w), 32'hFFFFFFFF);
      wr(3'd2, 2'(w), 32'h0);
    end
    #1;
    exp_oe = '0;
    for (int p = 0; p < 102; p++) if (p < 28 || p > 33) exp_oe[p] = 1'b1;
    chk(128'(pin_oe), exp_oe, "R10 all mapped pins driven, 28-33 idle");
    for (int w = 0; w < 4; w++) wr(3'd2, 2'(w), 32'hFFFFFFFF);
    wr(3'd2, 2'd2, 32'h7FFFFFFF);
    wr(3'd2, 2'd1, 32'hFFFFFFFE);
    #1;
    exp_oe = '0; exp_oe[97] = 1'b1; exp_oe[34] = 1'b1;
    chk(128'(pin_oe), exp_oe, "R10 pins 97 and 34");
    wr(3'd2, 2'd2, 32'hFFFFFFFF);
    wr(3'd2, 2'd1, 32'hFFFFFFFF);

    // R5 synchronised input
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (2) @(posedge clk);
    rd(3'd3, 2'd0, 32'h10, "R5 pin 0 at position 4");
    @(negedge clk); pin_in[101] = 1'b1; pin_in[34] = 1'b1;
    repeat (2) @(posedge clk);
    rd(3'd3, 2'd0, 32'h11, "R5 R10 pin 101 at position 0");
    rd(3'd3, 2'd1, 32'h1, "R5 R10 pin 34 at position 32");
    settle();
    rd(3'd5, 2'd0, 32'h0, "R6 rising ignored in falling mode");

    // R6 edge polarity
    wr(3'd6, 2'd0, 32'h10);
    @(negedge clk); pin_in[101] = 1'b0; pin_in[0] = 1'b0;
    settle();
    rd(3'd5, 2'd0, 32'h1, "R6 falling flagged, rising-mode pin quiet");
    @(negedge clk); pin_in[0] = 1'b1;
    settle();
    rd(3'd5, 2'd0, 32'h11, "R6 rising flagged");
    #1 chk(128'(irq), '0, "R7 masked status keeps irq low");

    // R7 mask, R8 clear
    wr(3'd4, 2'd0, 32'hFFFFFFEF);
    #1 chk(128'(irq), 128'(1), "R7 unmasked status raises irq");
    wr(3'd5, 2'd0, 32'hFFFFFFEF);
    rd(3'd5, 2'd0, 32'h1, "R8 zero clears, one keeps");
    #1 chk(128'(irq), '0, "R7 irq drops after clear");
    wr(3'd5, 2'd0, 32'h0);
    rd(3'd5, 2'd0, 32'h0, "R8 clear all");

    // R4 disabled pin raises no status
    wr(3'd0, 2'd0, 32'hFFFFFFEF);
    @(negedge clk); pin_in[0] = 1'b0;
    settle();
    @(negedge clk); pin_in[0] = 1'b1;
    settle();
    rd(3'd5, 2'd0, 32'h0, "R4 disabled pin no status");
    #1 chk(128'(irq), '0, "R4 disabled pin no irq");

    // R11 level mode instance
    lwrite(3'd4, 1'b0, 32'h0);
    @(negedge clk); lpin_in[5] = 1'b1;
    settle();
    lread(3'd5, 1'b0, 32'h20, "R11 level sets status");
    #1 chk(128'(lirq), 128'(1), "R11 level irq");
    lwrite(3'd5, 1'b0, 32'h0);
    lread(3'd5, 1'b0, 32'h20, "R11 level re-sets while high");
    @(negedge clk); lpin_in[5] = 1'b0;
    settle();
    lwrite(3'd5, 1'b0, 32'h0);
    lread(3'd5, 1'b0, 32'h0, "R11 cleared after level drops");
    #1 chk(128'(lirq), '0, "R11 irq low");

    summary();
    $finish;
  end
endmodule